// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block turns a bank of asynchronous input pins into interrupt lines. Each line watches one pin, at the line's own index, taken from one of several ports. It can react to rising edges, falling edges or both. Each accepted edge leaves a sticky pending flag. That flag raises the line's interrupt request when the line's interrupt mask lets it through. The same edge can also give a single-clock event pulse, under a separate event mask.

All pins pass through a two-stage synchronizer before the source multiplexer and the edge detector. Software sets up the bank through a flat register port that is written synchronously and read combinationally. Software clears pending flags by writing ones. A combined request output reports the channel number of the lowest-numbered active line. Line 0 is channel 6, and the higher lines follow in sequence.

Top module: `ext_irq_edge`

## Requirements
- R1: After reset every register reads zero, every source select points to port A (select code 0), and `irq_o`, `evt_o`, `irq_any` and `irq_chan` are all zero.
- R2: Register 0 holds a 2-bit source select for each line, at bits [2i+1:2i] for line i. Code p routes pin p*LINES+i of `pins_i` to line i. Pins of other ports at that index have no effect on the line.
- R3: With the line's bit set in the rising-enable register (address 3), a low-to-high pin change sets the line's pending bit on the third rising clock edge after the change, and not before. With the bit clear, a rising change sets nothing.
- R4: With only the line's bit set in the falling-enable register (address 4), a high-to-low change sets the pending bit with the same latency, and a low-to-high change sets nothing.
- R5: When both enables of a line are set, either edge sets its pending bit. When neither is set, no edge does.
- R6: Pending bits (address 5) stay set until a write of a one to that bit position at address 5. Zero bits in that write leave their lines unchanged. An accepted edge in the same cycle as the clearing write keeps the bit set.
- R7: `irq_o[i]` is high exactly while line i is pending and its bit in the interrupt mask register (address 1) is one.
- R8: An accepted edge drives `evt_o[i]` high for exactly one clock, in the cycle the pending bit becomes set, only if the line's bit in the event mask register (address 2) is one. The pending bit is set whatever the state of either mask.
- R9: `irq_any` is high while any `irq_o` bit is high. `irq_chan` then equals 6 plus the index of the lowest active line, and it is zero otherwise.
- R10: Addresses 0 to 4 read back what was written, limited to the implemented bits. Address 5 reads the pending bits, and any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | PORTS*LINES (20) | Asynchronous pin inputs; port p, index i at bit p*LINES+i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| irq_o | output | LINES (5) | Per-line interrupt request |
| evt_o | output | LINES (5) | Per-line one-clock event pulse |
| irq_any | output | 1 | Any line requesting |
| irq_chan | output | CHAN_W (8) | Channel number of the lowest requesting line |

## Verification
Pin changes are applied on a falling clock edge. The pending bit and the event pulse are due on the third rising edge after the change. The bench reads the pending register after two rising edges to confirm nothing has arrived early, and again after the third edge to see the bit. It samples the event output after the third and the fourth edge to prove the pulse lasts one clock. Mask and pending writes take effect on the rising edge that captures them, so the interrupt outputs and read data are checked on the falling edge that follows. For the edge-versus-clear race, the clearing write is timed to land on that third edge.

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
  parameter int LINES     = 5,
  parameter int PORTS     = 4,
  parameter int DATA_W    = 32,
  parameter int CHAN_BASE = 6,
  parameter int CHAN_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PORTS*LINES-1:0] pins_i,
  input  logic                   reg_wr,
  input  logic [2:0]             reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic [LINES-1:0]       irq_o,
  output logic [LINES-1:0]       evt_o,
  output logic                   irq_any,
  output logic [CHAN_W-1:0]      irq_chan
);
  localparam int SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1;
  localparam int PINS  = PORTS * LINES;
  localparam logic [2:0] A_SEL = 3'd0, A_IMASK = 3'd1, A_EMASK = 3'd2,
                         A_RISE = 3'd3, A_FALL = 3'd4, A_PEND = 3'd5;

  logic [LINES*SEL_W-1:0] sel_q;
  logic [LINES-1:0] imask_q, emask_q, rise_q, fall_q, pend_q, evt_q;
  logic [LINES-1:0] prev_q, cur, edge_hit, clr;
  logic [PINS-1:0]  sync1_q, sync2_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  // two-stage synchronizer on every pin
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pins_i;
      sync2_q <= sync1_q;
    end

  // per-line port select
  always_comb
    for (int i = 0; i < LINES; i++) begin
      int p;
      p = int'(sel_q[i*SEL_W +: SEL_W]);
      cur[i] = (p < PORTS) ? sync2_q[p*LINES + i] : 1'b0;
    end

  assign edge_hit = (cur & ~prev_q & rise_q) | (~cur & prev_q & fall_q);
  assign clr      = (reg_wr && reg_addr == A_PEND) ? reg_wdata[LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= '0; imask_q <= '0; emask_q <= '0;
      rise_q <= '0; fall_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_SEL:   sel_q   <= reg_wdata[LINES*SEL_W-1:0];
        A_IMASK: imask_q <= reg_wdata[LINES-1:0];
        A_EMASK: emask_q <= reg_wdata[LINES-1:0];
        A_RISE:  rise_q  <= reg_wdata[LINES-1:0];
        A_FALL:  fall_q  <= reg_wdata[LINES-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= cur;
      pend_q <= (pend_q & ~clr) | edge_hit;
      evt_q  <= edge_hit & emask_q;
    end

  assign irq_o   = pend_q & imask_q;
  assign evt_o   = evt_q;
  assign irq_any = |irq_o;

  always_comb begin
    irq_chan = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (irq_o[i]) irq_chan = CHAN_W'(CHAN_BASE + i);
  end

  always_comb
    case (reg_addr)
      A_SEL:   reg_rdata = DATA_W'(sel_q);
      A_IMASK: reg_rdata = DATA_W'(imask_q);
      A_EMASK: reg_rdata = DATA_W'(emask_q);
      A_RISE:  reg_rdata = DATA_W'(rise_q);
      A_FALL:  reg_rdata = DATA_W'(fall_q);
      A_PEND:  reg_rdata = DATA_W'(pend_q);
      default: reg_rdata = '0;
    endcase

  p_new_pend_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(edge_hit)) == '0));

  p_edge_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & ~(rise_q | fall_q)) == '0);

  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PEND) |=>
      ((pend_q & $past(reg_wdata[LINES-1:0]) & ~$past(edge_hit)) == '0));

  p_evt_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & ~$past(emask_q)) == '0) && ((evt_o & ~pend_q) == '0));

  p_chan_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (irq_chan >= CHAN_W'(CHAN_BASE)) && (irq_chan < CHAN_W'(CHAN_BASE + LINES)));
endmodule

// File: tb/test_ext_irq_edge.sv
`timescale 1ns/1ps
module test_ext_irq_edge;
  localparam int LINES = 5, PORTS = 4, DATA_W = 32, CHAN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PORTS*LINES-1:0] pins = '0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
  logic [LINES-1:0] irq_o, evt_o;
  logic irq_any;
  logic [CHAN_W-1:0] irq_chan;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  ext_irq_edge i_ext_irq_edge (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .evt_o(evt_o),
    .irq_any(irq_any), .irq_chan(irq_chan));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cfg(logic [31:0] sel, logic [31:0] im, logic [31:0] em,
                     logic [31:0] re, logic [31:0] fe);
    wr(3'd0, sel); wr(3'd1, im); wr(3'd2, em); wr(3'd3, re); wr(3'd4, fe);
    wr(3'd5, 32'h1f);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    check("R1 irq/evt/any/chan after reset", {irq_o, evt_o, irq_any, irq_chan}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(3'd0, 32'hffff_f2e4); wr(3'd1, 32'hffff_ff15); wr(3'd2, 32'h0a);
    wr(3'd3, 32'h13); wr(3'd4, 32'h0c); wr(3'd7, 32'hffff_ffff);
    rd(3'd0, d); check("R10 select readback", d, 32'h2e4);
    rd(3'd1, d); check("R10 irq mask readback", d, 32'h15);
    rd(3'd2, d); check("R10 event mask readback", d, 32'h0a);
    rd(3'd3, d); check("R10 rise readback", d, 32'h13);
    rd(3'd4, d); check("R10 fall readback", d, 32'h0c);
    rd(3'd6, d); check("R10 unused address 6", d, 0);
    rd(3'd7, d); check("R10 unused address 7", d, 0);
    cfg(0, 0, 0, 0, 0);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    cfg(0, 0, 0, 32'h01, 0);
    pins[0] = 1'b1;
    cyc(2); rd(3'd5, d); check("R3 rise not before third edge", d, 0);
    cyc(1); rd(3'd5, d); check("R3 rise pending on third edge", d, 32'h01);
    wr(3'd5, 32'h01);
    pins[0] = 1'b0;
    cyc(4); rd(3'd5, d); check("R3 falling edge ignored when rise only", d, 0);
    wr(3'd3, 0);
    pins[0] = 1'b1; cyc(4); rd(3'd5, d); check("R3 rise disabled sets nothing", d, 0);
    pins[0] = 1'b0; cyc(4);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    cfg(0, 0, 0, 0, 32'h02);
    pins[1] = 1'b1;
    cyc(4); rd(3'd5, d); check("R4 rising ignored in falling-only", d, 0);
    pins[1] = 1'b0;
    cyc(2); rd(3'd5, d); check("R4 fall not before third edge", d, 0);
    cyc(1); rd(3'd5, d); check("R4 fall pending on third edge", d, 32'h02);
  endtask

  task automatic t_both;
    logic [31:0] d;
    cfg(0, 0, 0, 32'h04, 32'h04);
    pins[2] = 1'b1; cyc(3); rd(3'd5, d); check("R5 both: rising sets", d, 32'h04);
    wr(3'd5, 32'h04);
    pins[2] = 1'b0; cyc(3); rd(3'd5, d); check("R5 both: falling sets", d, 32'h04);
    wr(3'd5, 32'h04);
    pins[3] = 1'b1; cyc(4); pins[3] = 1'b0; cyc(4);
    rd(3'd5, d); check("R5 no enables: nothing pends", d, 0);
  endtask

  task automatic t_sel;
    logic [31:0] d;
    cfg(32'h200, 0, 0, 32'h10, 0);
    pins[4] = 1'b1; cyc(4);
    rd(3'd5, d); check("R2 port A pin ignored when port C selected", d, 0);
    pins[4] = 1'b0; cyc(4);
    pins[2*LINES+4] = 1'b1; cyc(3);
    rd(3'd5, d); check("R2 port C pin drives line 4", d, 32'h10);
    pins[2*LINES+4] = 1'b0; cyc(4);
    cfg(0, 0, 0, 0, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    cfg(0, 0, 0, 32'h01, 0);
    pins[0] = 1'b1; cyc(3);
    wr(3'd5, 32'h00); rd(3'd5, d); check("R6 zero write keeps pending", d, 32'h01);
    wr(3'd5, 32'h1e); rd(3'd5, d); check("R6 other-bit clear keeps pending", d, 32'h01);
    pins[0] = 1'b0; cyc(4);
    pins[0] = 1'b1; cyc(2);
    wr(3'd5, 32'h01); rd(3'd5, d); check("R6 edge wins over same-cycle clear", d, 32'h01);
    wr(3'd5, 32'h01); rd(3'd5, d); check("R6 write one clears", d, 0);
    pins[0] = 1'b0; cyc(4);
  endtask

  task automatic t_mask;
    cfg(0, 0, 0, 32'h01, 0);
    pins[0] = 1'b1; cyc(3);
    check("R7 pending but masked gives no irq", irq_o, 0);
    wr(3'd1, 32'h01);
    check("R7 unmasked pending gives irq", irq_o, 32'h01);
    wr(3'd5, 32'h01);
    check("R7 cleared pending drops irq", irq_o, 0);
    pins[0] = 1'b0; cyc(4);
  endtask

  task automatic t_evt;
    logic [31:0] d;
    cfg(0, 0, 32'h04, 32'h04, 0);
    pins[2] = 1'b1;
    cyc(2); check("R8 no event before third edge", evt_o, 0);
    cyc(1); check("R8 event pulse on third edge", evt_o, 32'h04);
    cyc(1); check("R8 event lasts one clock", evt_o, 0);
    check("R8 irq masked despite event", irq_o, 0);
    wr(3'd2, 0); wr(3'd5, 32'h04);
    pins[2] = 1'b0; cyc(4); pins[2] = 1'b1;
    cyc(3); check("R8 event masked off", evt_o, 0);
    rd(3'd5, d); check("R8 pending set with masks off", d, 32'h04);
    pins[2] = 1'b0; cyc(4);
  endtask

  task automatic t_chan;
    cfg(0, 32'h0a, 0, 32'h1f, 0);
    pins[1] = 1'b1; pins[3] = 1'b1; pins[4] = 1'b1; cyc(3);
    check("R9 lowest active line 1 gives channel 7", {irq_any, irq_chan}, {1'b1, 8'd7});
    wr(3'd5, 32'h02);
    check("R9 line 3 gives channel 9", {irq_any, irq_chan}, {1'b1, 8'd9});
    wr(3'd5, 32'h08);
    check("R9 masked line 4 only: no request", {irq_any, irq_chan}, 0);
    wr(3'd1, 32'h01); wr(3'd5, 32'h1f);
    pins = '0; pins[0] = 1'b1; cyc(3);
    check("R9 line 0 gives channel 6", {irq_any, irq_chan}, {1'b1, 8'd6});
    pins = '0; cyc(4);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset(); t_regs(); t_rise(); t_fall(); t_both(); t_sel();
    t_w1c(); t_mask(); t_evt(); t_chan();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule